// File: doc/BRIEF.md
# MDIO Management Frame Controller

A management-bus master for attached Ethernet PHYs. Software programs a clock divisor, then writes one 32-bit command word that already holds the whole management frame: start, opcode, PHY address, register address, turnaround and 16 data bits. The controller sends 32 preamble ones and then the command word, most significant bit first. It generates MDC itself and drives MDIO through a separate output-enable.

For a read opcode the controller lets go of MDIO from the turnaround onward. It samples the PHY's 16 data bits on MDC rising edges and places them in the low half of the data register. At the end of the frame it sets a completion event that software clears by writing a one to it.

The register bus has a write strobe, a 2-bit address, write data and combinational read data. The registers are:

- event register at address 0, with completion in bit 23;
- data/command register at address 1;
- speed register at address 2, with the divisor field in bits 6:1.

Top module: `mdio_master`

## Requirements
- R1: After reset MDC is low, the MDIO enable is low, and addresses 0, 1 and 2 all read zero.
- R2: A transaction drives MDIO with the enable high, one bit per MDC period. It sends 32 ones first, then command bits 31 down to 0. Each bit changes only while MDC is low, starting at the falling edge.
- R3: When command bits 29:28 equal 2'b10 (a read), the enable is low from command bit 17 (the turnaround) to the end of the frame. MDIO input is sampled on the MDC rising edge of each of the last 16 bit periods, most significant bit first.
- R4: With F the value of speed-register bits 6:1, each MDC high and low phase lasts F clock cycles. MDC starts low on the cycle after the command write and is low whenever the controller is idle.
- R5: After the 64th MDC period the controller goes idle with MDC and the enable low, and sets bit 23 of address 0. For a read, bits 15:0 of address 1 then hold the sampled data, while bits 31:16 keep the command.
- R6: A write to address 0 with bit 23 set clears the event. With bit 23 clear the write leaves the event unchanged. A completion in the same cycle as a clear leaves the event set.
- R7: While F is zero, a write to address 1 is ignored: no transaction starts, MDC stays low, and address 1 keeps its value.
- R8: A write to address 1 while a transaction is in progress is ignored. The frame continues unchanged and the register contents are not replaced.
- R9: For any opcode other than 2'b10 the enable stays high for all 64 bits. Address 1 still reads the written command after completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO value seen on the pin |

## Verification
The assertions assume the speed field is not rewritten while a frame is in flight, since the phase counter compares against the live field. The stimulus therefore writes the speed register only while idle. It drives the PHY's response on mdio_in during the low half of each MDC period, so the value is settled at the rising edge. Bus writes are single-cycle strobes. One of them is placed deliberately on the cycle the frame completes, to exercise the clear-versus-set ordering.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W    = 6,
  parameter int PRE_BITS = 32,
  parameter int EVT_BIT  = 23
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  localparam int FRAME_BITS = PRE_BITS + 32;
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] PRE_END  = CNT_W'(PRE_BITS);
  localparam logic [CNT_W-1:0] TA_IDX   = CNT_W'(PRE_BITS + 14);
  localparam logic [CNT_W-1:0] DAT_IDX  = CNT_W'(PRE_BITS + 16);

  logic [31:0]      cmd;
  logic [15:0]      rx;
  logic [DIV_W-1:0] spd, div_cnt;
  logic [CNT_W-1:0] bit_cnt, pos;
  logic             busy, mdc_q, evt;

  wire is_rd    = cmd[29:28] == 2'b10;
  wire wr_evt   = bus_we && bus_addr == 2'd0;
  wire wr_dat   = bus_we && bus_addr == 2'd1;
  wire wr_spd   = bus_we && bus_addr == 2'd2;
  wire start    = wr_dat && !busy && spd != '0;
  wire half_end = busy && div_cnt == spd - DIV_W'(1);
  wire done     = half_end && mdc_q && bit_cnt == LAST_IDX;

  assign pos      = LAST_IDX - bit_cnt;
  assign mdc      = mdc_q;
  assign mdio_oe  = busy && !(is_rd && bit_cnt >= TA_IDX);
  assign mdio_out = (bit_cnt < PRE_END) ? 1'b1 : cmd[pos[4:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd <= '0; rx <= '0; spd <= '0; div_cnt <= '0;
      bit_cnt <= '0; busy <= 1'b0; mdc_q <= 1'b0;
    end else begin
      if (wr_spd) spd <= bus_wdata[DIV_W:1];
      if (start) begin
        cmd <= bus_wdata; busy <= 1'b1; div_cnt <= '0;
        bit_cnt <= '0; mdc_q <= 1'b0;
      end else if (busy) begin
        if (half_end) begin
          div_cnt <= '0;
          mdc_q   <= ~mdc_q;
          if (!mdc_q) begin
            if (bit_cnt >= DAT_IDX) rx <= {rx[14:0], mdio_in};
          end else if (bit_cnt == LAST_IDX) begin
            busy <= 1'b0;
            if (is_rd) cmd[15:0] <= rx;
          end else begin
            bit_cnt <= bit_cnt + CNT_W'(1);
          end
        end else begin
          div_cnt <= div_cnt + DIV_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt <= 1'b0;
    else if (done) evt <= 1'b1;
    else if (wr_evt && bus_wdata[EVT_BIT]) evt <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      2'd0: bus_rdata[EVT_BIT] = evt;
      2'd1: bus_rdata = cmd;
      2'd2: bus_rdata[DIV_W:1] = spd;
      default: bus_rdata = '0;
    endcase
  end

  // R4
  mdc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && div_cnt != '0) |-> $stable(mdc_q));
  // R5
  evt_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (evt && !mdc_q && !mdio_oe));
  // R6
  evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && bus_wdata[EVT_BIT] && !done) |=> !evt);
  // R7
  zero_speed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && spd == '0) |=> (!busy && !mdc_q));
  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_dat && !done) |=> $stable(cmd));
endmodule

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, mdio_in = 1'b1;
  logic [1:0] bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic mdc, mdio_out, mdio_oe;

  mdio_master dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;

  bit m_busy = 0, m_evt = 0, m_done = 0, was_busy;
  int m_k = 0, m_f = 0;
  logic [31:0] m_cmd = '0;
  logic [15:0] phy_word = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // reference model, advanced on every clock edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_evt = 0; m_k = 0; m_f = 0; m_cmd = '0;
    end else begin
      was_busy = m_busy;
      m_done = 0;
      if (m_busy) begin
        m_k++;
        if (m_k == 128 * m_f) begin
          m_busy = 0; m_evt = 1; m_done = 1;
          if (m_cmd[29:28] == 2'b10) m_cmd[15:0] = phy_word;
        end
      end
      if (bus_we && bus_addr == 2'd0 && bus_wdata[23] && !m_done) m_evt = 0;
      if (bus_we && bus_addr == 2'd1 && !was_busy && m_f != 0) begin
        m_busy = 1; m_k = 0; m_cmd = bus_wdata;
      end
      if (bus_we && bus_addr == 2'd2) m_f = int'(bus_wdata[6:1]);
    end
  end

  // compare every clock, then present the PHY's bit for the next edge
  always @(negedge clk) begin
    if (rst_n) begin
      automatic int bitn = m_busy ? m_k / (2 * m_f) : 0;
      automatic bit rd = m_cmd[29:28] == 2'b10;
      automatic bit e_mdc = m_busy ? ((m_k / m_f) % 2 == 1) : 1'b0;
      automatic bit e_oe = m_busy && !(rd && bitn >= 46);
      automatic logic [31:0] e_rd = '0;
      chk(mdc == e_mdc, "R4", "mdc", mdc, e_mdc);
      chk(mdio_oe == e_oe, "R3", "mdio_oe", mdio_oe, e_oe);
      if (e_oe) begin
        automatic bit e_out = (bitn < 32) ? 1'b1 : m_cmd[63 - bitn];
        chk(mdio_out == e_out, "R2", "mdio_out", mdio_out, e_out);
      end
      case (bus_addr)
        2'd0: e_rd[23] = m_evt;
        2'd1: e_rd = m_cmd;
        2'd2: e_rd[6:1] = 6'(m_f);
        default: e_rd = '0;
      endcase
      chk(bus_rdata == e_rd, "R5", "bus_rdata", bus_rdata, e_rd);
      mdio_in = (m_busy && rd && bitn >= 48) ? phy_word[63 - bitn] : 1'b1;
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); #1; bus_addr = a;
    @(negedge clk);
    chk(bus_rdata == exp, tag, "register", bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  initial begin
    logic [31:0] c;
    idle(3); #1; rst_n = 1'b1;
    // R1 reset state
    peek(2'd0, 32'h0, "R1"); peek(2'd1, 32'h0, "R1"); peek(2'd2, 32'h0, "R1");
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1", "pins", {mdc, mdio_oe}, 0);
    // R7 zero speed: command ignored
    bus_wr(2'd1, 32'h6002_0000); idle(10);
    peek(2'd1, 32'h0, "R7");
    chk(mdc == 1'b0, "R7", "mdc idle", mdc, 0);
    // R3/R4/R5 read at F=2, with R8 write during busy
    bus_wr(2'd2, 32'd4); peek(2'd2, 32'd4, "R4");
    phy_word = 16'hBEEF;
    c = 32'h6002_0000 | (32'd5 << 23) | (32'd3 << 18);
    bus_wr(2'd1, c); idle(20);
    bus_wr(2'd1, 32'h5002_5555);
    peek(2'd1, c, "R8");
    idle(260);
    peek(2'd1, {c[31:16], 16'hBEEF}, "R3");
    peek(2'd0, 32'h0080_0000, "R5");
    // R6 write-one-to-clear
    bus_wr(2'd0, 32'h0000_FFC0); peek(2'd0, 32'h0080_0000, "R6");
    bus_wr(2'd0, 32'h0080_0000); peek(2'd0, 32'h0, "R6");
    // R9 write at F=1, completion coinciding with a clear
    bus_wr(2'd2, 32'd2);
    c = 32'h5002_0000 | (32'd17 << 23) | (32'd9 << 18) | 32'h1234;
    bus_wr(2'd1, c);
    idle(126);
    bus_wr(2'd0, 32'h0080_0000);
    peek(2'd0, 32'h0080_0000, "R6");
    peek(2'd1, c, "R9");
    bus_wr(2'd0, 32'hFFFF_FFFF); peek(2'd0, 32'h0, "R6");
    // R3 read at F=3 with edge data bits
    bus_wr(2'd2, 32'd6);
    phy_word = 16'h8001;
    c = 32'h6002_0000 | (32'd31 << 23) | (32'd31 << 18);
    bus_wr(2'd1, c); idle(400);
    peek(2'd1, {c[31:16], 16'h8001}, "R3");
    peek(2'd0, 32'h0080_0000, "R5");
    finish_run();
  end
endmodule